// File: doc/BRIEF.md
# Stream Dispatch and Fault Recording Front End

This block is the control front end of a system address translation unit. Each incoming transaction carries an address, a security bit and a stream identifier. The security bit chooses one of two configuration banks, Secure or Non-secure. Each bank has its own stream table and its own global control. The stream identifier is then matched against that bank's table. The winning entry names the translation mechanism and a context index. The result is one registered decision per transaction for the translation engine behind it: bypass, stage 1, stage 2, stage 1 then stage 2, or fault. The decision carries the context index and that context's table-endianness bit.

Faults are kept in status records that software clears by writing ones. A fault found before any context is chosen goes into the bank's global record: either the bank forces a fault, or no table entry matches the stream. A fault from a matched entry whose mode says fault goes into the record of the entry's context. Each record keeps the syndrome of the first fault. Later faults only set a multiple-fault flag. Each record drives an interrupt when its enable is set.

Top module: `sdr_dispatch_top`

## Requirements
- R1: `in_sec` picks the bank. Value 0 uses the Non-secure stream table and global control, and value 1 uses the Secure ones. Entries and control in the other bank have no effect on the decision.
- R2: Each bank has NENT (16) stream entries. An entry matches when it is valid and `in_sid` equals its ID in every bit where its mask bit is 0. When several entries match, the lowest index wins.
- R3: A matched entry's mode sets `out_kind`: 0 is bypass, 1 is stage 1, 2 is stage 2 and 3 is stage 1 then stage 2. The decision also carries the entry's context index on `out_ctx` and that context's big-endian bit on `out_big_endian`.
- R4: The bank's force-fault bit gives `out_kind` = 4 (fault) whatever the table holds. The bank's force-bypass bit gives 0 (bypass) whatever the table holds. Force-fault wins over force-bypass. Forced results carry context 0 and endianness 0.
- R5: A forced fault, or a stream that matches no entry, is recorded in the global record of the transaction's bank. `gfsr_cause` is 1 for forced and 0 for unmatched, and `gfsr_sid` holds the stream ID. The output kind is 4, with context 0.
- R6: A matched entry with mode 4 or above gives kind 4. The fault is recorded in the record of that entry's context, with `cfsr_sec` and `cfsr_sid` taken from the transaction.
- R7: A record keeps its first syndrome while its fault flag stays set. A further fault only sets the record's multiple-fault flag.
- R8: A clear write of bit 0 clears a record's fault flag, and a write of bit 1 clears its multiple flag. A fault in the same cycle as a clear is recorded as a new first fault.
- R9: A record's interrupt is high exactly when its fault flag and its interrupt enable are both set. It drops in the cycle after the flag is cleared.
- R10: `in_ready` is high when the output register is empty or `out_ready` is high. An accepted transaction shows on the output in the next cycle. The output stays stable while it is held back.
- R11: After reset, every table entry is invalid, all controls are 0, all records are clear, and `out_valid` and all interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction valid |
| in_ready | output | 1 | Transaction accepted this cycle when valid |
| in_sec | input | 1 | Originator security state, 1 = Secure |
| in_sid | input | SIDW | Stream identifier |
| in_addr | input | AW | Transaction address |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Downstream takes the decision |
| out_kind | output | 3 | 0 bypass, 1 S1, 2 S2, 3 S1+S2, 4 fault |
| out_ctx | output | CTXW | Context index |
| out_big_endian | output | 1 | Context table endianness, 1 = big |
| out_sec | output | 1 | Security bit of the transaction |
| out_sid | output | SIDW | Stream ID of the transaction |
| out_addr | output | AW | Address of the transaction |
| cfg_ste_we | input | 1 | Stream entry write |
| cfg_ste_sec | input | 1 | Bank of the entry write |
| cfg_ste_idx | input | IDXW | Entry index |
| cfg_ste_valid | input | 1 | Entry valid |
| cfg_ste_id | input | SIDW | Entry ID |
| cfg_ste_mask | input | SIDW | Entry mask, 1 = ignore bit |
| cfg_ste_mode | input | 3 | Entry mode, 0..3 translate, 4+ fault |
| cfg_ste_ctx | input | CTXW | Entry context index |
| cfg_glb_we | input | 1 | Bank control write |
| cfg_glb_sec | input | 1 | Bank of the control write |
| cfg_glb_irq_en | input | 1 | Global interrupt enable |
| cfg_glb_force_byp | input | 1 | Force bypass |
| cfg_glb_force_flt | input | 1 | Force fault |
| cfg_ctx_we | input | 1 | Context control write |
| cfg_ctx_idx | input | CTXW | Context index |
| cfg_ctx_big_endian | input | 1 | Context big-endian tables |
| cfg_ctx_irq_en | input | 1 | Context interrupt enable |
| gfsr_clr_we | input | 1 | Global record clear write |
| gfsr_clr_sec | input | 1 | Bank to clear |
| gfsr_clr_bits | input | 2 | Bit 0 fault flag, bit 1 multiple flag |
| cfsr_clr_we | input | 1 | Context record clear write |
| cfsr_clr_idx | input | CTXW | Context to clear |
| cfsr_clr_bits | input | 2 | Bit 0 fault flag, bit 1 multiple flag |
| gfsr_fault | output | 2 | Global fault flag per bank (bit 1 Secure) |
| gfsr_multi | output | 2 | Global multiple flag per bank |
| gfsr_cause | output | 2 | Global cause per bank, 1 forced |
| gfsr_sid | output | 2*SIDW | Global syndrome stream ID per bank |
| cfsr_fault | output | NCTX | Context fault flags |
| cfsr_multi | output | NCTX | Context multiple flags |
| cfsr_sec | output | NCTX | Context syndrome security bit |
| cfsr_sid | output | NCTX*SIDW | Context syndrome stream IDs |
| irq_global | output | 2 | Global interrupts per bank |
| irq_ctx | output | NCTX | Context interrupts |

## Verification
A corrupted table entry or a wrong bank choice shows on `out_kind` and `out_ctx` one cycle after the next transaction with that stream ID is accepted. A record that loses its first syndrome, or fails to set its multiple flag, differs from the bench model on the record outputs one cycle after the second fault. A wrong enable or clear path shows on the interrupt lines in the cycle after the write. The bench compares every output against its model in every cycle, so each such divergence is caught at its first visible cycle.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    K_BYPASS = 3'd0,
    K_S1     = 3'd1,
    K_S2     = 3'd2,
    K_S12    = 3'd3,
    K_FAULT  = 3'd4
  } kind_e;

  localparam logic CAUSE_UNMATCHED = 1'b0;
  localparam logic CAUSE_FORCED    = 1'b1;
endpackage

// File: rtl/sdr_stream_table.sv
module sdr_stream_table #(
  parameter int NENT = 16,
  parameter int SIDW = 8,
  parameter int CTXW = 2,
  parameter int IDXW = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_valid,
  input  logic [SIDW-1:0] wr_id,
  input  logic [SIDW-1:0] wr_mask,
  input  logic [2:0]      wr_mode,
  input  logic [CTXW-1:0] wr_ctx,
  input  logic [SIDW-1:0] lk_sid,
  output logic            lk_hit,
  output logic [2:0]      lk_mode,
  output logic [CTXW-1:0] lk_ctx
);
  logic [NENT-1:0] vld_q, vld_d;
  logic [SIDW-1:0] id_q   [NENT];
  logic [SIDW-1:0] id_d   [NENT];
  logic [SIDW-1:0] mask_q [NENT];
  logic [SIDW-1:0] mask_d [NENT];
  logic [2:0]      mode_q [NENT];
  logic [2:0]      mode_d [NENT];
  logic [CTXW-1:0] ctx_q  [NENT];
  logic [CTXW-1:0] ctx_d  [NENT];
  logic [NENT-1:0] match;
  logic [NENT-1:0] sel;

  // next state: one entry written per cycle
  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < NENT; i++) begin
      id_d[i]   = id_q[i];
      mask_d[i] = mask_q[i];
      mode_d[i] = mode_q[i];
      ctx_d[i]  = ctx_q[i];
      if (wr_en && (wr_idx == IDXW'(i))) begin
        vld_d[i]  = wr_valid;
        id_d[i]   = wr_id;
        mask_d[i] = wr_mask;
        mode_d[i] = wr_mode;
        ctx_d[i]  = wr_ctx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NENT; i++) begin
        id_q[i]   <= '0;
        mask_q[i] <= '0;
        mode_q[i] <= '0;
        ctx_q[i]  <= '0;
      end
    end else if (wr_en) begin
      vld_q <= vld_d;
      for (int i = 0; i < NENT; i++) begin
        id_q[i]   <= id_d[i];
        mask_q[i] <= mask_d[i];
        mode_q[i] <= mode_d[i];
        ctx_q[i]  <= ctx_d[i];
      end
    end
  end

  // masked compare, lowest index wins
  always_comb begin
    sel     = '0;
    lk_mode = '0;
    lk_ctx  = '0;
    for (int i = 0; i < NENT; i++)
      match[i] = vld_q[i] && (((lk_sid ^ id_q[i]) & ~mask_q[i]) == '0);
    for (int i = NENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel     = '0;
        sel[i]  = 1'b1;
        lk_mode = mode_q[i];
        lk_ctx  = ctx_q[i];
      end
    end
    lk_hit = |match;
  end

  a_r2_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  a_r2_pick_is_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((sel & match) != '0));
endmodule

// File: rtl/sdr_fault_rec.sv
module sdr_fault_rec #(
  parameter int SYNW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic [SYNW-1:0] set_syn,
  input  logic            clr_we,
  input  logic [1:0]      clr_bits,
  input  logic            irq_en,
  output logic            fault_o,
  output logic            multi_o,
  output logic [SYNW-1:0] syn_o,
  output logic            irq_o
);
  logic            fault_q, fault_d, multi_q, multi_d;
  logic [SYNW-1:0] syn_q, syn_d;
  logic            fault_c, multi_c, upd;

  always_comb begin
    fault_c = fault_q & ~(clr_we & clr_bits[0]);
    multi_c = multi_q & ~(clr_we & clr_bits[1]);
    fault_d = fault_c;
    multi_d = multi_c;
    syn_d   = syn_q;
    if (set) begin
      if (fault_c) begin
        multi_d = 1'b1;
      end else begin
        fault_d = 1'b1;
        syn_d   = set_syn;
      end
    end
    upd = set | clr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      multi_q <= 1'b0;
      syn_q   <= '0;
    end else if (upd) begin
      fault_q <= fault_d;
      multi_q <= multi_d;
      syn_q   <= syn_d;
    end
  end

  assign fault_o = fault_q;
  assign multi_o = multi_q;
  assign syn_o   = syn_q;
  assign irq_o   = fault_q & irq_en;

  a_r7_syn_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !(clr_we && clr_bits[0])) |=> $stable(syn_o));
  a_r7_second_multi: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && set && !(clr_we && clr_bits[0])) |=> multi_o);
  a_r9_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[0] && !set) |=> !irq_o);
endmodule

// File: rtl/sdr_dispatch_top.sv
module sdr_dispatch_top
  import sdr_pkg::*;
#(
  parameter int NENT = 16,
  parameter int SIDW = 8,
  parameter int AW   = 32,
  parameter int NCTX = 4,
  parameter int IDXW = $clog2(NENT),
  parameter int CTXW = $clog2(NCTX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sec,
  input  logic [SIDW-1:0]      in_sid,
  input  logic [AW-1:0]        in_addr,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2:0]           out_kind,
  output logic [CTXW-1:0]      out_ctx,
  output logic                 out_big_endian,
  output logic                 out_sec,
  output logic [SIDW-1:0]      out_sid,
  output logic [AW-1:0]        out_addr,
  input  logic                 cfg_ste_we,
  input  logic                 cfg_ste_sec,
  input  logic [IDXW-1:0]      cfg_ste_idx,
  input  logic                 cfg_ste_valid,
  input  logic [SIDW-1:0]      cfg_ste_id,
  input  logic [SIDW-1:0]      cfg_ste_mask,
  input  logic [2:0]           cfg_ste_mode,
  input  logic [CTXW-1:0]      cfg_ste_ctx,
  input  logic                 cfg_glb_we,
  input  logic                 cfg_glb_sec,
  input  logic                 cfg_glb_irq_en,
  input  logic                 cfg_glb_force_byp,
  input  logic                 cfg_glb_force_flt,
  input  logic                 cfg_ctx_we,
  input  logic [CTXW-1:0]      cfg_ctx_idx,
  input  logic                 cfg_ctx_big_endian,
  input  logic                 cfg_ctx_irq_en,
  input  logic                 gfsr_clr_we,
  input  logic                 gfsr_clr_sec,
  input  logic [1:0]           gfsr_clr_bits,
  input  logic                 cfsr_clr_we,
  input  logic [CTXW-1:0]      cfsr_clr_idx,
  input  logic [1:0]           cfsr_clr_bits,
  output logic [1:0]           gfsr_fault,
  output logic [1:0]           gfsr_multi,
  output logic [1:0]           gfsr_cause,
  output logic [2*SIDW-1:0]    gfsr_sid,
  output logic [NCTX-1:0]      cfsr_fault,
  output logic [NCTX-1:0]      cfsr_multi,
  output logic [NCTX-1:0]      cfsr_sec,
  output logic [NCTX*SIDW-1:0] cfsr_sid,
  output logic [1:0]           irq_global,
  output logic [NCTX-1:0]      irq_ctx
);
  localparam int NBANK = 2;
  localparam int GSYNW = SIDW + 1;

  // per-bank lookup results
  logic            hit_b  [NBANK];
  logic [2:0]      mode_b [NBANK];
  logic [CTXW-1:0] ctx_b  [NBANK];

  // bank control and context control
  logic [NBANK-1:0] g_irq_en_q, g_irq_en_d, g_byp_q, g_byp_d, g_flt_q, g_flt_d;
  logic [NCTX-1:0]  c_be_q, c_be_d, c_irq_en_q, c_irq_en_d;

  // decision
  kind_e           kind_c;
  logic [CTXW-1:0] ctx_c;
  logic            be_c, gset_c, cset_c, cause_c, fire;

  // output register
  logic            ov_q, ov_d;
  kind_e           kind_q;
  logic [CTXW-1:0] ctx_q;
  logic            be_q, sec_q;
  logic [SIDW-1:0] sid_q;
  logic [AW-1:0]   addr_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [GSYNW-1:0] gsyn;
    sdr_stream_table #(.NENT(NENT), .SIDW(SIDW), .CTXW(CTXW), .IDXW(IDXW)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_ste_we && (cfg_ste_sec == b[0])),
      .wr_idx   (cfg_ste_idx),
      .wr_valid (cfg_ste_valid),
      .wr_id    (cfg_ste_id),
      .wr_mask  (cfg_ste_mask),
      .wr_mode  (cfg_ste_mode),
      .wr_ctx   (cfg_ste_ctx),
      .lk_sid   (in_sid),
      .lk_hit   (hit_b[b]),
      .lk_mode  (mode_b[b]),
      .lk_ctx   (ctx_b[b])
    );
    sdr_fault_rec #(.SYNW(GSYNW)) u_grec (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (fire && gset_c && (in_sec == b[0])),
      .set_syn  ({cause_c, in_sid}),
      .clr_we   (gfsr_clr_we && (gfsr_clr_sec == b[0])),
      .clr_bits (gfsr_clr_bits),
      .irq_en   (g_irq_en_q[b]),
      .fault_o  (gfsr_fault[b]),
      .multi_o  (gfsr_multi[b]),
      .syn_o    (gsyn),
      .irq_o    (irq_global[b])
    );
    assign gfsr_cause[b]                = gsyn[SIDW];
    assign gfsr_sid[b*SIDW +: SIDW]     = gsyn[SIDW-1:0];
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [GSYNW-1:0] csyn;
    sdr_fault_rec #(.SYNW(GSYNW)) u_crec (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (fire && cset_c && (ctx_c == CTXW'(c))),
      .set_syn  ({in_sec, in_sid}),
      .clr_we   (cfsr_clr_we && (cfsr_clr_idx == CTXW'(c))),
      .clr_bits (cfsr_clr_bits),
      .irq_en   (c_irq_en_q[c]),
      .fault_o  (cfsr_fault[c]),
      .multi_o  (cfsr_multi[c]),
      .syn_o    (csyn),
      .irq_o    (irq_ctx[c])
    );
    assign cfsr_sec[c]              = csyn[SIDW];
    assign cfsr_sid[c*SIDW +: SIDW] = csyn[SIDW-1:0];
  end

  // control registers: next state
  always_comb begin
    g_irq_en_d = g_irq_en_q;
    g_byp_d    = g_byp_q;
    g_flt_d    = g_flt_q;
    g_irq_en_d[cfg_glb_sec] = cfg_glb_irq_en;
    g_byp_d[cfg_glb_sec]    = cfg_glb_force_byp;
    g_flt_d[cfg_glb_sec]    = cfg_glb_force_flt;
    c_be_d     = c_be_q;
    c_irq_en_d = c_irq_en_q;
    c_be_d[cfg_ctx_idx]     = cfg_ctx_big_endian;
    c_irq_en_d[cfg_ctx_idx] = cfg_ctx_irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_irq_en_q <= '0;
      g_byp_q    <= '0;
      g_flt_q    <= '0;
    end else if (cfg_glb_we) begin
      g_irq_en_q <= g_irq_en_d;
      g_byp_q    <= g_byp_d;
      g_flt_q    <= g_flt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_be_q     <= '0;
      c_irq_en_q <= '0;
    end else if (cfg_ctx_we) begin
      c_be_q     <= c_be_d;
      c_irq_en_q <= c_irq_en_d;
    end
  end

  // dispatch decision: forced fault, forced bypass, unmatched, entry mode
  always_comb begin
    kind_c  = K_BYPASS;
    ctx_c   = '0;
    be_c    = 1'b0;
    gset_c  = 1'b0;
    cset_c  = 1'b0;
    cause_c = CAUSE_UNMATCHED;
    if (g_flt_q[in_sec]) begin
      kind_c  = K_FAULT;
      gset_c  = 1'b1;
      cause_c = CAUSE_FORCED;
    end else if (g_byp_q[in_sec]) begin
      kind_c = K_BYPASS;
    end else if (!hit_b[in_sec]) begin
      kind_c = K_FAULT;
      gset_c = 1'b1;
    end else begin
      ctx_c = ctx_b[in_sec];
      be_c  = c_be_q[ctx_b[in_sec]];
      if (mode_b[in_sec] >= 3'd4) begin
        kind_c = K_FAULT;
        cset_c = 1'b1;
      end else begin
        kind_c = kind_e'(mode_b[in_sec]);
      end
    end
  end

  assign in_ready = !ov_q || out_ready;
  assign fire     = in_valid && in_ready;

  always_comb begin
    ov_d = ov_q;
    if (fire)           ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_BYPASS;
      ctx_q  <= '0;
      be_q   <= 1'b0;
      sec_q  <= 1'b0;
      sid_q  <= '0;
      addr_q <= '0;
    end else if (fire) begin
      kind_q <= kind_c;
      ctx_q  <= ctx_c;
      be_q   <= be_c;
      sec_q  <= in_sec;
      sid_q  <= in_sid;
      addr_q <= in_addr;
    end
  end

  assign out_valid      = ov_q;
  assign out_kind       = kind_q;
  assign out_ctx        = ctx_q;
  assign out_big_endian = be_q;
  assign out_sec        = sec_q;
  assign out_sid        = sid_q;
  assign out_addr       = addr_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_sid)
                                   && $stable(out_ctx) && $stable(out_addr)));
  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  a_r4_forced_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && g_flt_q[in_sec]) |=> (out_kind == K_FAULT));
  a_r5_global_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && gset_c) |=> gfsr_fault[$past(in_sec)]);
  a_r6_ctx_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cset_c) |=> cfsr_fault[$past(ctx_c)]);
endmodule

// File: tb/tb_sdr_dispatch_top.sv
`timescale 1ns/1ps
module tb_sdr_dispatch_top;
  localparam int SIDW = 8, AW = 32, NCTX = 4, NENT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid, in_ready, in_sec, out_valid, out_ready, out_big_endian, out_sec;
  logic [SIDW-1:0] in_sid, out_sid;
  logic [AW-1:0] in_addr, out_addr;
  logic [2:0] out_kind;
  logic [1:0] out_ctx;
  logic cfg_ste_we, cfg_ste_sec, cfg_ste_valid;
  logic [3:0] cfg_ste_idx;
  logic [SIDW-1:0] cfg_ste_id, cfg_ste_mask;
  logic [2:0] cfg_ste_mode;
  logic [1:0] cfg_ste_ctx;
  logic cfg_glb_we, cfg_glb_sec, cfg_glb_irq_en, cfg_glb_force_byp, cfg_glb_force_flt;
  logic cfg_ctx_we, cfg_ctx_big_endian, cfg_ctx_irq_en;
  logic [1:0] cfg_ctx_idx;
  logic gfsr_clr_we, gfsr_clr_sec, cfsr_clr_we;
  logic [1:0] gfsr_clr_bits, cfsr_clr_bits, cfsr_clr_idx;
  logic [1:0] gfsr_fault, gfsr_multi, gfsr_cause, irq_global;
  logic [2*SIDW-1:0] gfsr_sid;
  logic [NCTX-1:0] cfsr_fault, cfsr_multi, cfsr_sec, irq_ctx;
  logic [NCTX*SIDW-1:0] cfsr_sid;

  sdr_dispatch_top dut (.*);

  // reference model state
  logic       t_vld [2][NENT];
  logic [7:0] t_id [2][NENT], t_mask [2][NENT];
  logic [2:0] t_mode [2][NENT];
  logic [1:0] t_ctx [2][NENT];
  logic [1:0] g_en, g_byp, g_flt, gf, gm, gc;
  logic [7:0] gsid [2];
  logic [3:0] c_be, c_en, cf, cm, csec;
  logic [7:0] csid [NCTX];
  logic m_ov, m_be, m_sec;
  logic [2:0] m_kind;
  logic [1:0] m_ctx;
  logic [7:0] m_sid;
  logic [31:0] m_addr;
  int nchk = 0, nfail = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {gset, cause, cset, kind[2:0], ctx[1:0], be}
  function automatic logic [8:0] decide(input logic s, input logic [7:0] sid);
    int hit;
    hit = -1;
    if (g_flt[s]) return {3'b110, 3'd4, 2'd0, 1'b0};
    if (g_byp[s]) return {3'b000, 3'd0, 2'd0, 1'b0};
    for (int i = NENT - 1; i >= 0; i--)
      if (t_vld[s][i] && (((sid ^ t_id[s][i]) & ~t_mask[s][i]) == 8'd0)) hit = i;
    if (hit < 0) return {3'b100, 3'd4, 2'd0, 1'b0};
    if (t_mode[s][hit] >= 3'd4) return {3'b001, 3'd4, t_ctx[s][hit], c_be[t_ctx[s][hit]]};
    return {3'b000, t_mode[s][hit], t_ctx[s][hit], c_be[t_ctx[s][hit]]};
  endfunction

  task automatic idle();
    in_valid = 0; in_sec = 0; in_sid = 0; in_addr = 0; out_ready = 1;
    cfg_ste_we = 0; cfg_ste_sec = 0; cfg_ste_idx = 0; cfg_ste_valid = 0; cfg_ste_id = 0;
    cfg_ste_mask = 0; cfg_ste_mode = 0; cfg_ste_ctx = 0;
    cfg_glb_we = 0; cfg_glb_sec = 0; cfg_glb_irq_en = 0; cfg_glb_force_byp = 0; cfg_glb_force_flt = 0;
    cfg_ctx_we = 0; cfg_ctx_idx = 0; cfg_ctx_big_endian = 0; cfg_ctx_irq_en = 0;
    gfsr_clr_we = 0; gfsr_clr_sec = 0; gfsr_clr_bits = 0;
    cfsr_clr_we = 0; cfsr_clr_idx = 0; cfsr_clr_bits = 0;
  endtask

  task automatic rec(inout logic f, inout logic m, inout logic [8:0] syn,
                     input logic clr, input logic [1:0] cb, input logic st, input logic [8:0] ns);
    if (clr && cb[0]) f = 0;
    if (clr && cb[1]) m = 0;
    if (st) begin
      if (f) m = 1;
      else begin f = 1; syn = ns; end
    end
  endtask

  // one clock: inputs set by caller; model advanced, then outputs compared
  task automatic cycle();
    logic rdy, fire;
    logic [8:0] d, syn;
    logic [15:0] gs_exp;
    logic [31:0] cs_exp;
    logic [1:0] ge;
    logic [3:0] ce;
    #1;
    rdy = !m_ov || out_ready;
    fire = in_valid && rdy;
    check("R10 in_ready", in_ready, rdy);
    d = decide(in_sec, in_sid);
    for (int b = 0; b < 2; b++) begin
      syn = {gc[b], gsid[b]};
      rec(gf[b], gm[b], syn, gfsr_clr_we && gfsr_clr_sec == b[0], gfsr_clr_bits,
          fire && d[8] && in_sec == b[0], {d[7], in_sid});
      gc[b] = syn[8]; gsid[b] = syn[7:0];
    end
    for (int c = 0; c < NCTX; c++) begin
      syn = {csec[c], csid[c]};
      rec(cf[c], cm[c], syn, cfsr_clr_we && cfsr_clr_idx == c[1:0], cfsr_clr_bits,
          fire && d[6] && d[2:1] == c[1:0], {in_sec, in_sid});
      csec[c] = syn[8]; csid[c] = syn[7:0];
    end
    if (cfg_ste_we) begin
      t_vld[cfg_ste_sec][cfg_ste_idx] = cfg_ste_valid; t_id[cfg_ste_sec][cfg_ste_idx] = cfg_ste_id;
      t_mask[cfg_ste_sec][cfg_ste_idx] = cfg_ste_mask; t_mode[cfg_ste_sec][cfg_ste_idx] = cfg_ste_mode;
      t_ctx[cfg_ste_sec][cfg_ste_idx] = cfg_ste_ctx;
    end
    if (cfg_glb_we) begin
      g_en[cfg_glb_sec] = cfg_glb_irq_en; g_byp[cfg_glb_sec] = cfg_glb_force_byp;
      g_flt[cfg_glb_sec] = cfg_glb_force_flt;
    end
    if (cfg_ctx_we) begin
      c_be[cfg_ctx_idx] = cfg_ctx_big_endian; c_en[cfg_ctx_idx] = cfg_ctx_irq_en;
    end
    if (fire) begin
      m_ov = 1; m_kind = d[5:3]; m_ctx = d[2:1]; m_be = d[0];
      m_sec = in_sec; m_sid = in_sid; m_addr = in_addr;
    end else if (out_ready) m_ov = 0;
    @(negedge clk);
    check("R10 out_valid", out_valid, m_ov);
    if (m_ov) begin
      check("R3 out_kind", out_kind, m_kind);
      check("R3 out_ctx", out_ctx, m_ctx);
      check("R3 out_big_endian", out_big_endian, m_be);
      check("R10 out_sid/sec/addr", {out_sec, out_sid, out_addr}, {m_sec, m_sid, m_addr});
    end
    gs_exp = {gsid[1], gsid[0]};
    for (int c = 0; c < NCTX; c++) cs_exp[c*8 +: 8] = csid[c];
    check("R5 gfsr", {gfsr_fault, gfsr_cause, gfsr_sid}, {gf, gc, gs_exp});
    check("R6 cfsr", {cfsr_fault, cfsr_sec, cfsr_sid}, {cf, csec, cs_exp});
    check("R7 multi", {gfsr_multi, cfsr_multi}, {gm, cm});
    ge = gf & g_en; ce = cf & c_en;
    check("R9 irq", {irq_global, irq_ctx}, {ge, ce});
    idle();
  endtask

  task automatic ste(input logic s, input int idx, input logic [7:0] id, input logic [7:0] mask,
                     input logic [2:0] mode, input logic [1:0] ctx);
    cfg_ste_we = 1; cfg_ste_sec = s; cfg_ste_idx = idx[3:0]; cfg_ste_valid = 1;
    cfg_ste_id = id; cfg_ste_mask = mask; cfg_ste_mode = mode; cfg_ste_ctx = ctx;
    cycle();
  endtask

  task automatic send(input logic s, input logic [7:0] sid);
    in_valid = 1; in_sec = s; in_sid = sid; in_addr = {24'hA5A5A5, sid};
    cycle();
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NENT; i++) begin
        t_vld[b][i] = 0; t_id[b][i] = 0; t_mask[b][i] = 0; t_mode[b][i] = 0; t_ctx[b][i] = 0;
      end
    g_en = 0; g_byp = 0; g_flt = 0; gf = 0; gm = 0; gc = 0; gsid[0] = 0; gsid[1] = 0;
    c_be = 0; c_en = 0; cf = 0; cm = 0; csec = 0;
    for (int c = 0; c < NCTX; c++) csid[c] = 0;
    m_ov = 0; m_kind = 0; m_ctx = 0; m_be = 0; m_sec = 0; m_sid = 0; m_addr = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    check("R11 reset out_valid/in_ready", {out_valid, in_ready}, 2'b01);
    check("R11 reset records", {gfsr_fault, gfsr_multi, cfsr_fault, cfsr_multi}, 12'd0);
    check("R11 reset irq", {irq_global, irq_ctx}, 6'd0);
    send(0, 8'h12);
    check("R11 empty table faults", out_kind, 3'd4);

    // R2: masked match and lowest-index priority
    ste(0, 3, 8'h10, 8'h0F, 3'd1, 2'd1);
    ste(0, 1, 8'h12, 8'h00, 3'd2, 2'd2);
    ste(1, 0, 8'h12, 8'h00, 3'd3, 2'd3);
    cfg_ctx_we = 1; cfg_ctx_idx = 2; cfg_ctx_big_endian = 1; cycle();
    send(0, 8'h12);
    check("R2 lowest index wins", {out_kind, out_ctx}, {3'd2, 2'd2});
    check("R3 endian forwarded", out_big_endian, 1'b1);
    send(0, 8'h1D);
    check("R2 masked bits ignored", {out_kind, out_ctx}, {3'd1, 2'd1});
    send(1, 8'h12);
    check("R1 secure bank used", {out_kind, out_ctx}, {3'd3, 2'd3});
    send(1, 8'h15);
    check("R1 other bank entry ignored", out_kind, 3'd4);

    // R5/R7/R8: global records
    gfsr_clr_we = 1; gfsr_clr_sec = 0; gfsr_clr_bits = 2'b11;
    gfsr_clr_we = 1; gfsr_clr_sec = 1; cycle();
    gfsr_clr_we = 1; gfsr_clr_sec = 0; gfsr_clr_bits = 2'b11; cycle();
    send(0, 8'h40);
    check("R5 unmatched recorded", {gfsr_fault[0], gfsr_cause[0], gfsr_sid[7:0]}, {2'b10, 8'h40});
    send(0, 8'h41);
    check("R7 first syndrome kept", gfsr_sid[7:0], 8'h40);
    check("R7 multi set", gfsr_multi[0], 1'b1);
    gfsr_clr_we = 1; gfsr_clr_sec = 0; gfsr_clr_bits = 2'b01; cycle();
    check("R8 clear bit0 only", {gfsr_fault[0], gfsr_multi[0]}, 2'b01);
    gfsr_clr_bits = 2'b01; gfsr_clr_we = 1; in_valid = 1; in_sid = 8'h42; send(0, 8'h42);
    check("R8 set with clear is fresh", {gfsr_fault[0], gfsr_sid[7:0]}, {1'b1, 8'h42});

    // R6/R9: context fault and its interrupt
    ste(0, 2, 8'h20, 8'h00, 3'd4, 2'd0);
    cfg_ctx_we = 1; cfg_ctx_idx = 0; cfg_ctx_irq_en = 1; cycle();
    send(0, 8'h20);
    check("R6 context record", {cfsr_fault[0], cfsr_sec[0], cfsr_sid[7:0]}, {2'b10, 8'h20});
    check("R9 irq raised", irq_ctx[0], 1'b1);
    cfsr_clr_we = 1; cfsr_clr_idx = 0; cfsr_clr_bits = 2'b01; cycle();
    check("R9 irq dropped", irq_ctx[0], 1'b0);

    // R4: forced bypass and forced fault
    cfg_glb_we = 1; cfg_glb_sec = 0; cfg_glb_force_byp = 1; cycle();
    send(0, 8'h77);
    check("R4 forced bypass", {out_kind, out_ctx}, {3'd0, 2'd0});
    cfg_glb_we = 1; cfg_glb_sec = 0; cfg_glb_force_byp = 1; cfg_glb_force_flt = 1; cfg_glb_irq_en = 1; cycle();
    gfsr_clr_we = 1; gfsr_clr_sec = 0; gfsr_clr_bits = 2'b11; cycle();
    send(0, 8'h12);
    check("R4 forced fault wins", out_kind, 3'd4);
    check("R5 forced cause", gfsr_cause[0], 1'b1);
    check("R9 global irq", irq_global[0], 1'b1);
    cfg_glb_we = 1; cfg_glb_sec = 0; cycle();

    // R10: back-pressure
    in_valid = 1; in_sid = 8'h12; out_ready = 0; cycle();
    in_valid = 1; in_sid = 8'h1D; out_ready = 0; cycle();
    check("R10 held output", out_sid, 8'h12);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      in_valid = ($urandom % 4) != 0; in_sec = $urandom % 2;
      in_sid = $urandom % 32; in_addr = $urandom; out_ready = ($urandom % 4) != 0;
      if ($urandom % 6 == 0) begin
        cfg_ste_we = 1; cfg_ste_sec = $urandom % 2; cfg_ste_idx = $urandom % 16;
        cfg_ste_valid = ($urandom % 5) != 0; cfg_ste_id = $urandom % 32;
        cfg_ste_mask = $urandom % 4; cfg_ste_mode = $urandom % 6; cfg_ste_ctx = $urandom % 4;
      end
      if ($urandom % 20 == 0) begin
        cfg_glb_we = 1; cfg_glb_sec = $urandom % 2; cfg_glb_irq_en = $urandom % 2;
        cfg_glb_force_byp = ($urandom % 4) == 0; cfg_glb_force_flt = ($urandom % 4) == 0;
      end
      if ($urandom % 10 == 0) begin
        cfg_ctx_we = 1; cfg_ctx_idx = $urandom % 4;
        cfg_ctx_big_endian = $urandom % 2; cfg_ctx_irq_en = $urandom % 2;
      end
      if ($urandom % 8 == 0) begin
        gfsr_clr_we = 1; gfsr_clr_sec = $urandom % 2; gfsr_clr_bits = $urandom % 4;
      end
      if ($urandom % 8 == 0) begin
        cfsr_clr_we = 1; cfsr_clr_idx = $urandom % 4; cfsr_clr_bits = $urandom % 4;
      end
      cycle();
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule